// File: doc/BRIEF.md
# Mixed-Sign 16x16 Multiplier Unit

This unit carries out the plain multiply instruction of a 16-bit processor core. It decodes the instruction word and reports the two source register indices to an external register file. It takes the two 16-bit register values that the file returns in the same cycle. Twelve cycles later it delivers the 32-bit product for the fixed destination pair. The upper half is meant for R4 and the lower half for R3, and both halves come with a single write strobe.

The multiply has two modes. In the first, both operands are treated as unsigned. In the second, the first operand is a two's-complement value and the second operand is unsigned. The signed product is not formed with a signed multiplier. The datapath builds the unsigned product with an iterative shift-add. When the signed operand is negative, it then takes the second operand, shifted up by sixteen, away from that product modulo 2^32.

The multiply-and-sum form of the instruction is recognised, but it is not executed. Issuing it raises a one-cycle "unsupported" indication. Any other instruction presented on the issue port has no effect.

Top module: `mixmul_unit`

## Requirements
- R1: An issued word is a plain multiply when (word AND 0xF0F8) equals 0xE008. For any word, the first source index output equals word bits 11:9 and the second equals word bits 2:0.
- R2: When word bit 8 is 0, the product is the unsigned first operand times the unsigned second operand, taken as 32 bits.
- R3: When word bit 8 is 1, the product is the two's-complement first operand times the unsigned second operand, modulo 2^32. This equals the unsigned product less (second operand << 16) when first-operand bit 15 is set.
- R4: The result high output carries product bits 31:16 (destined for R4). The result low output carries bits 15:0 (destined for R3). Both change only in the cycle where the done strobe is high.
- R5: The issue is accepted on a clock edge where start is high and busy is low. After that edge, busy is high for exactly 12 cycles. On the edge that drops busy, done goes high for one cycle together with the new result.
- R6: A start seen while busy is high is ignored. Busy does not lengthen, and the result belongs to the accepted instruction.
- R7: A word with (word AND 0xF080) equal to 0xE080 that is issued while idle raises the unsupported output for exactly the next cycle. It leaves busy low, gives no done strobe, and leaves the results unchanged.
- R8: An issued word that matches neither pattern produces no busy, no done and no unsupported indication, and leaves the results unchanged.
- R9: After reset, busy, done and unsupported are 0 and both result outputs are 0x0000.
- R10: The result outputs hold their value from one done strobe to the next.
- R11: Operand values are captured on the acceptance edge. Changes on the operand inputs while busy do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue strobe for the instruction word |
| instr | input | 16 | Instruction word |
| opnd_a | input | 16 | Value of the first source register |
| opnd_b | input | 16 | Value of the second source register |
| rf_idx_a | output | 3 | Register file index of the first source |
| rf_idx_b | output | 3 | Register file index of the second source |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle write strobe for both result halves |
| res_hi | output | 16 | Product bits 31:16, destined for R4 |
| res_lo | output | 16 | Product bits 15:0, destined for R3 |
| unsup | output | 1 | One-cycle flag for the multiply-and-sum form |

## Verification
Busy is due one cycle after the acceptance edge. Done and both result halves are due exactly twelve cycles after that edge. The unsupported flag is due one cycle after its issue edge. The bench drives all inputs on falling edges and samples every output on falling edges. It counts the falling edges that see busy high until done appears, and requires that count to be exactly twelve with done and busy low in the same sample. The result, the idle state and the unchanged results for ignored words are all compared at the sample where they are due. The next sample then confirms that done and the unsupported flag have cleared.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned IDX_W  = 3;

  localparam logic [WORD_W-1:0] MUL_MASK    = 16'hF0F8;
  localparam logic [WORD_W-1:0] MUL_MATCH   = 16'hE008;
  localparam logic [WORD_W-1:0] MULSUM_MASK = 16'hF080;
  localparam logic [WORD_W-1:0] MULSUM_MATCH = 16'hE080;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'd0,
    CLS_MUL    = 2'd1,
    CLS_MULSUM = 2'd2
  } instr_cls_e;

  // classify a word against the two multiply patterns
  function automatic instr_cls_e classify(input logic [WORD_W-1:0] w);
    if ((w & MUL_MASK) == MUL_MATCH)          return CLS_MUL;
    else if ((w & MULSUM_MASK) == MULSUM_MATCH) return CLS_MULSUM;
    else                                      return CLS_OTHER;
  endfunction

  // correction term for signed-by-unsigned mode
  function automatic logic [2*WORD_W-1:0] sign_fix(
    input logic              signed_mode,
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b
  );
    if (signed_mode && a[WORD_W-1]) return {b, {WORD_W{1'b0}}};
    else                            return '0;
  endfunction
endpackage

// File: rtl/mixmul_decode.sv
module mixmul_decode
  import mixmul_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output instr_cls_e        cls,
  output logic              signed_sel,
  output logic [IDX_W-1:0]  idx_a,
  output logic [IDX_W-1:0]  idx_b
);
  always_comb begin
    cls        = classify(instr);
    signed_sel = instr[8];
    idx_a      = instr[11:9];
    idx_b      = instr[2:0];
  end
endmodule

// File: rtl/mixmul_seq.sv
module mixmul_seq #(
  parameter int unsigned LAT   = 12,
  parameter int unsigned STEPS = 8,
  localparam int unsigned CW   = $clog2(LAT + 1),
  localparam int unsigned SIW  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  output logic           busy,
  output logic           step_en,
  output logic [SIW-1:0] step_idx,
  output logic           fin
);
  logic [CW-1:0] cnt;

  always_comb begin
    step_en  = busy && (cnt < CW'(STEPS));
    step_idx = cnt[SIW-1:0];
    fin      = busy && (cnt == CW'(LAT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (fin) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= CW'(LAT - 1))); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> (busy && cnt == $past(cnt) + 1'b1)); // R6
endmodule

// File: rtl/mixmul_datapath.sv
module mixmul_datapath
  import mixmul_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned DIG   = 2,
  localparam int unsigned STEPS = W / DIG,
  localparam int unsigned SIW  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           signed_in,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic           step_en,
  input  logic [SIW-1:0] step_idx,
  output logic [2*W-1:0] prod
);
  logic [W-1:0]   a_q, b_q;
  logic           sgn_q;
  logic [2*W-1:0] acc;
  logic [DIG-1:0] digit;
  logic [2*W-1:0] pp;
  logic [2*W-1:0] terms [DIG];
  logic [2*W-1:0] corr;

  assign digit = a_q[int'(step_idx) * DIG +: DIG];

  for (genvar i = 0; i < DIG; i++) begin : g_term
    assign terms[i] = digit[i] ? ({{W{1'b0}}, b_q} << i) : '0;
  end

  always_comb begin
    pp = '0;
    for (int i = 0; i < DIG; i++) pp = pp + terms[i];
  end

  assign corr = sign_fix(sgn_q, a_q, b_q);
  assign prod = acc - corr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      sgn_q <= 1'b0;
      acc   <= '0;
    end else if (load) begin
      a_q   <= a_in;
      b_q   <= b_in;
      sgn_q <= signed_in;
      acc   <= '0;
    end else if (step_en) begin
      acc <= acc + (pp << (int'(step_idx) * DIG));
    end
  end

  AST_OPND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(a_q) && $stable(b_q) && $stable(sgn_q))); // R11
endmodule

// File: rtl/mixmul_unit.sv
module mixmul_unit
  import mixmul_pkg::*;
#(
  parameter int unsigned LAT = 12,
  parameter int unsigned DIG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  output logic [IDX_W-1:0]  rf_idx_a,
  output logic [IDX_W-1:0]  rf_idx_b,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo,
  output logic              unsup
);
  localparam int unsigned STEPS = WORD_W / DIG;
  localparam int unsigned SIW   = (STEPS > 1) ? $clog2(STEPS) : 1;

  instr_cls_e          cls;
  logic                signed_sel;
  logic                accept, unsup_hit;
  logic                step_en, fin;
  logic [SIW-1:0]      step_idx;
  logic [2*WORD_W-1:0] prod;

  mixmul_decode u_dec (
    .instr      (instr),
    .cls        (cls),
    .signed_sel (signed_sel),
    .idx_a      (rf_idx_a),
    .idx_b      (rf_idx_b)
  );

  assign accept    = start && !busy && (cls == CLS_MUL);
  assign unsup_hit = start && !busy && (cls == CLS_MULSUM);

  mixmul_seq #(.LAT(LAT), .STEPS(STEPS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .busy     (busy),
    .step_en  (step_en),
    .step_idx (step_idx),
    .fin      (fin)
  );

  mixmul_datapath #(.W(WORD_W), .DIG(DIG)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .signed_in (signed_sel),
    .a_in      (opnd_a),
    .b_in      (opnd_b),
    .step_en   (step_en),
    .step_idx  (step_idx),
    .prod      (prod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      unsup  <= 1'b0;
      res_hi <= '0;
      res_lo <= '0;
    end else begin
      done  <= fin;
      unsup <= unsup_hit;
      if (fin) begin
        res_hi <= prod[2*WORD_W-1:WORD_W];
        res_lo <= prod[WORD_W-1:0];
      end
    end
  end

  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy)); // R5
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_hi) && $stable(res_lo))); // R10
  AST_UNSUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    unsup |-> (!busy && !done)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
endmodule

// File: tb/mixmul_unit_tb_top.sv
module mixmul_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [2:0]  rf_idx_a, rf_idx_b;
  logic        busy, done, unsup;
  logic [15:0] res_hi, res_lo;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mixmul_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .rf_idx_a(rf_idx_a), .rf_idx_b(rf_idx_b),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo), .unsup(unsup)
  );

  // {signed_mode, a, b}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h0000, 16'hFFFF}, {1'b0, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h8000, 16'h7FFF}, {1'b0, 16'h7FFF, 16'h8000},
    {1'b0, 16'h1234, 16'h5678}, {1'b1, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h8000, 16'hFFFF}, {1'b1, 16'h8000, 16'h7FFF},
    {1'b1, 16'h7FFF, 16'hFFFF}, {1'b1, 16'h0000, 16'h8000},
    {1'b1, 16'hABCD, 16'h1234}, {1'b1, 16'hFFFF, 16'h0001}
  };

  function automatic logic [31:0] expect_prod(input logic m, input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] sa, sb;
    sa = m ? $signed({{16{a[15]}}, a}) : $signed({16'h0000, a});
    sb = $signed({16'h0000, b});
    return 32'(sa * sb);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue a multiply; optionally inject a second start mid-run
  task automatic run_mul(input logic m, input logic [15:0] a, input logic [15:0] b, input bit inject);
    logic [15:0] w;
    logic [31:0] e;
    int n;
    w = 16'hE008 | (16'(3'd5) << 9) | (16'(m) << 8) | 16'(3'd2);
    e = expect_prod(m, a, b);
    @(negedge clk);
    start = 1'b1; instr = w; opnd_a = a; opnd_b = b;
    #1;
    check("R1 idx_a", 32'(rf_idx_a), 32'd5);
    check("R1 idx_b", 32'(rf_idx_b), 32'd2);
    @(negedge clk);
    start = 1'b0; opnd_a = ~a; opnd_b = b ^ 16'h5A5A;   // R11 operand changes while busy
    n = 0;
    while (!done && n < 40) begin
      if (busy) n++;
      if (inject && n == 4) begin
        start = 1'b1; instr = 16'hE108 | 16'(3'd1); opnd_a = 16'h0003; opnd_b = 16'h0007;  // R6
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(inject ? "R6 busy length" : "R5 busy length", 32'(n), 32'd12);
    check("R5 busy low at done", 32'(busy), 32'd0);
    check(m ? "R3 product" : "R2 product", {res_hi, res_lo}, e);
    check("R4 high half", 32'(res_hi), 32'(e[31:16]));
    @(negedge clk);
    check("R5 done one cycle", 32'(done), 32'd0);
    check("R10 hold", {res_hi, res_lo}, e);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    check("R9 busy", 32'(busy), 32'd0);
    check("R9 done", 32'(done), 32'd0);
    check("R9 unsup", 32'(unsup), 32'd0);
    check("R9 results", {res_hi, res_lo}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_mul(VEC[i][32], VEC[i][31:16], VEC[i][15:0], i == 4 || i == 10);

    // R7: multiply-and-sum form flagged, nothing else
    keep = {res_hi, res_lo};
    @(negedge clk);
    start = 1'b1; instr = 16'hE0A1; opnd_a = 16'h0002; opnd_b = 16'h0003;
    @(negedge clk);
    start = 1'b0;
    check("R7 unsup raised", 32'(unsup), 32'd1);
    check("R7 not busy", 32'(busy), 32'd0);
    check("R7 no done", 32'(done), 32'd0);
    @(negedge clk);
    check("R7 unsup one cycle", 32'(unsup), 32'd0);
    check("R7 results kept", {res_hi, res_lo}, keep);

    // R8: unrelated words ignored
    start = 1'b1; instr = 16'h1234;
    @(negedge clk);
    instr = 16'hE000;
    @(negedge clk);
    start = 1'b0;
    check("R8 not busy", 32'(busy), 32'd0);
    check("R8 no unsup", 32'(unsup), 32'd0);
    repeat (14) begin
      @(negedge clk);
      check("R8 no done", 32'(done), 32'd0);
    end
    check("R8 results kept", {res_hi, res_lo}, keep);

    // R1: index fields follow the word for any value
    instr = 16'h0E07; #1;
    check("R1 idx any word", {26'd0, rf_idx_a, rf_idx_b}, 32'h3F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule